// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational integer arithmetic and logic unit. It is built from a row of identical one-bit slices. Each slice forms the bitwise AND, the bitwise OR and a full-adder sum of its operand bits at the same time. A four-way selector in the slice then picks one of these, or an external "less" bit. The carry of each slice feeds the next one up, so the adder is a plain ripple chain.

A three-bit operation code controls the unit. Its top bit inverts the B operand in every slice and also acts as the carry into bit 0, which turns the adder into a subtractor. Its two low bits drive the selector in every slice. For signed set-on-less-than, a small comparison unit looks at the sign bits of A, B and the difference. It feeds its answer into the "less" input of slice 0, and every other slice sees 0 there. Because of this, the comparison stays correct even when the subtraction itself overflows.

Around the slices sit a zero detector, a signed-overflow detector that only answers for add and subtract, and an output stage that forces the result to 0 for the three undefined codes. The width is a parameter, 32 by default.

Top module: `alu32_sliced`

## Requirements
- R1: Code 000 gives result = A AND B, bit by bit.
- R2: Code 001 gives result = A OR B, bit by bit.
- R3: Code 010 gives result = (A + B) mod 2^WIDTH.
- R4: Code 110 gives result = (A - B) mod 2^WIDTH.
- R5: Code 111 gives result = 1 when A < B as two's-complement numbers, and 0 otherwise. This holds even when A - B overflows.
- R6: carry_out is bit WIDTH of the adder chain for every code. It is A + B when code bit 2 is 0, and A + NOT B + 1 when code bit 2 is 1.
- R7: For code 010, overflow is 1 exactly when the signed sum A + B lies outside the two's-complement range of WIDTH bits.
- R8: For code 110, overflow is 1 exactly when the signed difference A - B lies outside that range.
- R9: For every code other than 010 and 110, overflow is 0.
- R10: zero is 1 exactly when all WIDTH result bits are 0.
- R11: The undefined codes 011, 100 and 101 give result = 0, so zero = 1 for them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | Operand A |
| b_in | input | WIDTH | Operand B |
| op_in | input | 3 | Operation code (bit 2 inverts B and is the carry into bit 0; bits 1:0 pick the slice output) |
| result | output | WIDTH | Selected result |
| carry_out | output | 1 | Carry out of the top slice |
| zero | output | 1 | All result bits are 0 |
| overflow | output | 1 | Signed overflow on add or subtract |

## Verification
A 4-bit copy of the unit is swept over every pair of operands under all eight codes, including the undefined ones. This exposes any slice-select, carry-chain or sign-logic fault at each operand magnitude, and every overflow and signed-compare corner is reached, including compares where the difference overflows. The 32-bit unit is driven with the extreme values 0, 1, -1, the largest positive and the most negative number, crossed with each other. These separate the carry-out from the overflow and check the compare at the ends of the range. A run of pseudo-random pairs then confirms that the carry ripples correctly across long propagate chains, which the small sweep cannot show.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } slice_sel_e;

  function automatic logic op_defined(logic [2:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_ADD) ||
           (op == OP_SUB) || (op == OP_SLT);
  endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu32_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       b_invert,
  input  logic       carry_in,
  input  logic       less,
  input  logic [1:0] sel,
  output logic       res,
  output logic       carry_o
);

  logic b_eff;
  logic sum;

  assign b_eff   = b ^ b_invert;
  assign sum     = a ^ b_eff ^ carry_in;
  assign carry_o = (a & b_eff) | (a & carry_in) | (b_eff & carry_in);

  always_comb begin
    unique case (sel)
      SEL_AND: res = a & b_eff;
      SEL_OR:  res = a | b_eff;
      SEL_SUM: res = sum;
      default: res = less;
    endcase
  end

endmodule

// File: rtl/alu_slice_msb.sv
module alu_slice_msb (
  input  logic       a,
  input  logic       b,
  input  logic       b_invert,
  input  logic       carry_in,
  input  logic       less,
  input  logic [1:0] sel,
  output logic       res,
  output logic       carry_o,
  output logic       sum_sign
);

  alu_slice u_core (
    .a        (a),
    .b        (b),
    .b_invert (b_invert),
    .carry_in (carry_in),
    .less     (less),
    .sel      (sel),
    .res      (res),
    .carry_o  (carry_o)
  );

  assign sum_sign = a ^ b ^ b_invert ^ carry_in;

endmodule

// File: rtl/alu_slt_unit.sv
module alu_slt_unit (
  input  logic a_sign,
  input  logic b_sign,
  input  logic diff_sign,
  output logic less
);

  // Equal signs: the difference cannot overflow, so its sign decides.
  // Unequal signs: the negative operand is the smaller one.
  always_comb begin
    if (a_sign == b_sign) less = diff_sign;
    else                  less = a_sign;
  end

endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage
  import alu32_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       op,
  input  logic             a_sign,
  input  logic             b_sign,
  input  logic             sum_sign,
  input  logic [WIDTH-1:0] raw_res,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow
);

  logic is_add;
  logic is_sub;

  assign is_add = (op == OP_ADD);
  assign is_sub = (op == OP_SUB);

  always_comb begin
    overflow = 1'b0;
    if (is_add) overflow = (a_sign == b_sign) && (sum_sign != a_sign);
    if (is_sub) overflow = (a_sign != b_sign) && (sum_sign != a_sign);
  end

  assign result = op_defined(op) ? raw_res : '0;
  assign zero   = ~|result;

endmodule

// File: rtl/alu32_sliced.sv
module alu32_sliced
  import alu32_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [2:0]       op_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             zero,
  output logic             overflow
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] less_w;
  logic [WIDTH-1:0] slice_res;
  logic             sum_msb;
  logic             slt_bit;

  assign carry[0]  = op_in[2];
  assign less_w    = {{(WIDTH-1){1'b0}}, slt_bit};
  assign carry_out = carry[WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == MSB) begin : g_top
      alu_slice_msb u_bit (
        .a        (a_in[i]),
        .b        (b_in[i]),
        .b_invert (op_in[2]),
        .carry_in (carry[i]),
        .less     (less_w[i]),
        .sel      (op_in[1:0]),
        .res      (slice_res[i]),
        .carry_o  (carry[i+1]),
        .sum_sign (sum_msb)
      );
    end else begin : g_low
      alu_slice u_bit (
        .a        (a_in[i]),
        .b        (b_in[i]),
        .b_invert (op_in[2]),
        .carry_in (carry[i]),
        .less     (less_w[i]),
        .sel      (op_in[1:0]),
        .res      (slice_res[i]),
        .carry_o  (carry[i+1])
      );
    end
  end

  alu_slt_unit u_slt (
    .a_sign    (a_in[MSB]),
    .b_sign    (b_in[MSB]),
    .diff_sign (sum_msb),
    .less      (slt_bit)
  );

  alu_out_stage #(.WIDTH(WIDTH)) u_out (
    .op       (op_in),
    .a_sign   (a_in[MSB]),
    .b_sign   (b_in[MSB]),
    .sum_sign (sum_msb),
    .raw_res  (slice_res),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
  );

endmodule

// File: rtl/alu32_sliced_chk.sv
module alu32_sliced_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [2:0]       op_in,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             zero,
  input logic             overflow
);

  logic [WIDTH:0] add_wide;
  logic [WIDTH:0] sub_wide;
  logic [WIDTH:0] sadd_ext;
  logic [WIDTH:0] ssub_ext;

  assign add_wide = {1'b0, a_in} + {1'b0, b_in};
  assign sub_wide = {1'b0, a_in} + {1'b0, ~b_in} + {{WIDTH{1'b0}}, 1'b1};
  assign sadd_ext = {a_in[WIDTH-1], a_in} + {b_in[WIDTH-1], b_in};
  assign ssub_ext = {a_in[WIDTH-1], a_in} - {b_in[WIDTH-1], b_in};

  always_comb begin
    if (op_in == 3'b000) begin
      assert_and_R1: assert (result == (a_in & b_in));
    end
    if (op_in == 3'b010) begin
      assert_add_R3: assert ({carry_out, result} == add_wide);
      assert_add_ovf_R7: assert (overflow == (sadd_ext[WIDTH] ^ sadd_ext[WIDTH-1]));
    end
    if (op_in == 3'b110) begin
      assert_sub_R4: assert ({carry_out, result} == sub_wide);
      assert_sub_ovf_R8: assert (overflow == (ssub_ext[WIDTH] ^ ssub_ext[WIDTH-1]));
    end
    if (op_in == 3'b111) begin
      assert_slt_R5: assert (result == {{(WIDTH-1){1'b0}}, ($signed(a_in) < $signed(b_in))});
    end
    if (op_in != 3'b010 && op_in != 3'b110) begin
      assert_no_overflow_R9: assert (!overflow);
    end
    if (op_in == 3'b011 || op_in == 3'b100 || op_in == 3'b101) begin
      assert_undef_zero_R11: assert (result == '0 && zero);
    end
  end

endmodule

bind alu32_sliced alu32_sliced_chk #(.WIDTH(WIDTH)) u_chk (
  .a_in      (a_in),
  .b_in      (b_in),
  .op_in     (op_in),
  .result    (result),
  .carry_out (carry_out),
  .zero      (zero),
  .overflow  (overflow)
);

// File: tb/alu32_sliced_tb.sv
`timescale 1ns/1ps
module alu32_sliced_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] a32, b32, r32;
  logic [2:0]  op32;
  logic        co32, z32, ov32;
  logic [3:0]  a4, b4, r4;
  logic [2:0]  op4;
  logic        co4, z4, ov4;

  int total = 0;
  int bad = 0;
  bit done = 0;

  alu32_sliced #(.WIDTH(32)) u_dut (
    .a_in(a32), .b_in(b32), .op_in(op32),
    .result(r32), .carry_out(co32), .zero(z32), .overflow(ov32));

  alu32_sliced #(.WIDTH(4)) u_dut_w4 (
    .a_in(a4), .b_in(b4), .op_in(op4),
    .result(r4), .carry_out(co4), .zero(z4), .overflow(ov4));

  function automatic string res_tag(logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R11";
    endcase
  endfunction

  function automatic string ovf_tag(logic [2:0] op);
    if (op == 3'b010) return "R7";
    if (op == 3'b110) return "R8";
    return "R9";
  endfunction

  task automatic check(string tag, longint act, longint exp, int w,
                       logic [31:0] a, logic [31:0] b, logic [2:0] op);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s w=%0d op=%b a=%h b=%h actual=%h expected=%h",
               tag, w, op, a, b, act, exp);
    end
  endtask

  task automatic run_case(int w, logic [31:0] a, logic [31:0] b, logic [2:0] op);
    longint m, ua, ub, sa, sb, bb, t, lo, hi, er, s;
    longint ar, eco, eov;
    m  = (longint'(1) << w) - 1;
    ua = longint'(a) & m;
    ub = longint'(b) & m;
    sa = ((ua >> (w-1)) & 1) != 0 ? ua - (m + 1) : ua;
    sb = ((ub >> (w-1)) & 1) != 0 ? ub - (m + 1) : ub;
    bb = op[2] ? ((~ub) & m) + 1 : ub;
    t  = ua + bb;
    s  = t & m;
    eco = (t >> w) & 1;
    hi = (m + 1) / 2 - 1;
    lo = -((m + 1) / 2);
    case (op)
      3'b000: er = ua & ub;
      3'b001: er = ua | ub;
      3'b010: er = s;
      3'b110: er = s;
      3'b111: er = (sa < sb) ? 1 : 0;
      default: er = 0;
    endcase
    eov = 0;
    if (op == 3'b010) eov = ((sa + sb) > hi || (sa + sb) < lo) ? 1 : 0;
    if (op == 3'b110) eov = ((sa - sb) > hi || (sa - sb) < lo) ? 1 : 0;

    @(posedge clk);
    #1;
    if (w == 4) begin a4 = a[3:0]; b4 = b[3:0]; op4 = op; end
    else        begin a32 = a; b32 = b; op32 = op; end
    @(negedge clk);
    if (w == 4) begin
      check(res_tag(op), longint'(r4), er, w, a, b, op);
      check("R6", longint'(co4), eco, w, a, b, op);
      check(ovf_tag(op), longint'(ov4), eov, w, a, b, op);
      check("R10", longint'(z4), (er == 0) ? 1 : 0, w, a, b, op);
    end else begin
      check(res_tag(op), longint'(r32), er, w, a, b, op);
      check("R6", longint'(co32), eco, w, a, b, op);
      check(ovf_tag(op), longint'(ov32), eov, w, a, b, op);
      check("R10", longint'(z32), (er == 0) ? 1 : 0, w, a, b, op);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=completion");
      finish_run();
    end
  end

  logic [31:0] corner [5];
  logic [31:0] seed;

  initial begin
    a32 = '0; b32 = '0; op32 = 3'b000;
    a4 = '0; b4 = '0; op4 = 3'b000;
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
    corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h8000_0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle state: AND of zero operands, flags quiet (R1, R10, R9)
    check("R1", longint'(r32), 0, 32, 0, 0, 0);
    check("R10", longint'(z32), 1, 32, 0, 0, 0);
    check("R9", longint'(ov32), 0, 32, 0, 0, 0);

    // Exhaustive sweep of the 4-bit unit (all requirements, all codes)
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run_case(4, 32'(a), 32'(b), 3'(op));

    // 32-bit extreme values crossed (R5 overflowing compares, R6, R7, R8)
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run_case(32, corner[i], corner[j], 3'(op));

    // 32-bit pseudo-random pairs for long carry chains (R3, R4, R6)
    seed = 32'h1234_5679;
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ra, rb;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      ra = seed;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      rb = (k % 4 == 0) ? ~ra : seed;
      for (int op = 0; op < 8; op++)
        run_case(32, ra, rb, 3'(op));
    end

    finish_run();
  end

endmodule